// File: doc/BRIEF.md
# Lane Deskew Elastic Buffer

This block sits on one receive lane of a multi-lane serial link and removes the skew between that lane and its neighbours. After the link leaves its synchronisation request, the lane first sees comma characters and then its first real word. From that word on, every valid word is stored in a small FIFO, together with one control-character flag per byte. Reading does not begin as soon as the FIFO holds data. It waits for the next pulse of the local multiframe clock, which every lane shares, so all lanes release their data on the same cycle and the latency is deterministic.

Write and read use one clock. The block reports how many words were held at the moment reading began, which is the lane's added latency. It also keeps sticky overflow and underflow flags. While synchronisation is requested the whole buffer is held empty. The depth is the number of 4-byte lane words in one multiframe (bytes per frame times frames per multiframe, divided by four), rounded up to a power of two.

Top module: `lane_skew_buffer`

## Requirements
- R1: While `rst` or `sync_req` is high, the next clock edge empties the buffer and clears `rd_active`, `ovf`, `unf`, `latency`, `rd_data` and `rd_ctrl` to zero.
- R2: A byte i is a comma when `wr_ctrl[i]` is 1 and `wr_data[8*i+7:8*i]` equals 8'hBC. Storing starts with the first word that has `wr_valid` high, `sync_req` low and no comma byte. That word and every later valid word are stored, including later commas. Earlier words are discarded.
- R3: `rd_active` rises at the edge where `lmfc` is high, provided a word was stored at an earlier edge. An `lmfc` pulse in the same cycle as the first store, or before it, has no effect. Once high, `rd_active` stays high until R1 applies.
- R4: While `rd_active` is high, one word is read each cycle. The word read appears on `rd_data`/`rd_ctrl` at the edge that ends that cycle, so the first stored word is visible one cycle after `rd_active` rises. Words come out in write order.
- R5: `latency` counts the words stored before `rd_active` rose, saturating at 255, and is frozen while `rd_active` is high.
- R6: A valid write that arrives when DEPTH words are held and no word leaves in the same cycle is dropped, and `ovf` is set. `ovf` stays set until R1 applies, and the stored words are kept intact.
- R7: A read cycle with zero words held leaves `rd_data`/`rd_ctrl` unchanged and sets `unf`, which stays set until R1 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock for both write and read |
| rst | input | 1 | Synchronous reset, active high |
| sync_req | input | 1 | High while the link requests synchronisation |
| wr_valid | input | 1 | Incoming lane word is valid |
| wr_data | input | 32 | Incoming lane word, byte 0 in bits 7:0 |
| wr_ctrl | input | 4 | Per-byte control-character flags of the incoming word |
| lmfc | input | 1 | Local multiframe clock pulse |
| rd_data | output | 32 | Delayed lane word |
| rd_ctrl | output | 4 | Per-byte control flags of the delayed word |
| rd_active | output | 1 | Reading has started |
| ovf | output | 1 | Sticky overflow flag |
| unf | output | 1 | Sticky underflow flag |
| latency | output | 8 | Words held when reading began |

## Verification
Every result is registered. `latency`, `ovf` and `unf` change at the edge that closes the cycle carrying the write or read. `rd_active` changes at the edge that samples `lmfc`. A read word reaches `rd_data` at the edge after the one that raised `rd_active`. For each cycle, the bench drives inputs one time unit after a rising edge and compares outputs one time unit after the next edge. A table row therefore holds the expected state produced by that row's own stimulus, and the first data word is expected on the row after `rd_active` turns on. Directed sequences cover an `lmfc` pulse in the same cycle as the first store, `lmfc` pulses while only commas arrive, words offered during a sync request, and a write one past full.

// File: rtl/lsb_pkg.sv
package lsb_pkg;

    localparam int unsigned LANE_BYTES = 4;
    localparam int unsigned LANE_BITS  = LANE_BYTES * 8;
    localparam logic [7:0]  COMMA_BYTE = 8'hBC;
    localparam int unsigned LAT_W      = 8;

    typedef struct packed {
        logic [LANE_BITS-1:0]  data;
        logic [LANE_BYTES-1:0] ctrl;
    } lane_word_t;

endpackage

// File: rtl/lsb_comma_detect.sv
module lsb_comma_detect
    import lsb_pkg::*;
(
    input  lane_word_t word_i,
    output logic       has_comma_o
);

    logic [LANE_BYTES-1:0] byte_hit;

    for (genvar gi = 0; gi < LANE_BYTES; gi++) begin : g_byte
        assign byte_hit[gi] = word_i.ctrl[gi] &&
                              (word_i.data[8*gi +: 8] == COMMA_BYTE);
    end

    assign has_comma_o = |byte_hit;

endmodule

// File: rtl/lsb_start_ctrl.sv
module lsb_start_ctrl
    import lsb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_req,
    input  logic             wr_valid,
    input  logic             has_comma,
    input  logic             lmfc,
    input  logic             push_ok,
    output logic             wr_en,
    output logic             rd_en,
    output logic [LAT_W-1:0] latency
);

    typedef struct packed {
        logic             wr_on;
        logic             rd_on;
        logic [LAT_W-1:0] lat;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic        clr;

    assign clr = rst || sync_req;

    always_comb begin
        st_d  = st_q;
        wr_en = wr_valid && !sync_req && (st_q.wr_on || !has_comma);
        if (clr) begin
            st_d = '0;
        end else begin
            if (wr_en) begin
                st_d.wr_on = 1'b1;
            end
            if (lmfc && st_q.wr_on) begin
                st_d.rd_on = 1'b1;
            end
            if (push_ok && !st_q.rd_on && (st_q.lat != {LAT_W{1'b1}})) begin
                st_d.lat = st_q.lat + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rd_en   = st_q.rd_on;
    assign latency = st_q.lat;

    AST_READ_HOLDS: assert property (@(posedge clk) disable iff (rst || sync_req)
        st_q.rd_on |=> st_q.rd_on);                                  // R3
    AST_READ_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst || sync_req)
        $rose(st_q.rd_on) |-> $past(st_q.wr_on));                    // R3
    AST_LAT_FROZEN: assert property (@(posedge clk) disable iff (rst || sync_req)
        st_q.rd_on |=> $stable(st_q.lat));                           // R5
    AST_NO_WRITE_IN_SYNC: assert property (@(posedge clk) disable iff (rst)
        sync_req |-> !wr_en);                                        // R2

endmodule

// File: rtl/lsb_fifo.sv
module lsb_fifo
    import lsb_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sync_req,
    input  logic       wr_en,
    input  lane_word_t wr_word,
    input  logic       rd_en,
    output logic       push_ok,
    output lane_word_t rd_word,
    output logic       ovf,
    output logic       unf
);

    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = AW + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          ovf;
        logic          unf;
        lane_word_t    out;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    lane_word_t  mem [DEPTH];
    logic        clr;
    logic        pop_ok;

    assign clr = rst || sync_req;

    always_comb begin
        st_d    = st_q;
        pop_ok  = rd_en && (st_q.cnt != '0);
        push_ok = wr_en && ((st_q.cnt != FULL_CNT) || pop_ok);
        if (clr) begin
            st_d    = '0;
            pop_ok  = 1'b0;
            push_ok = 1'b0;
        end else begin
            if (push_ok) begin
                st_d.wp = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
            end
            if (pop_ok) begin
                st_d.rp  = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
                st_d.out = mem[st_q.rp];
            end
            st_d.cnt = st_q.cnt + CW'(push_ok) - CW'(pop_ok);
            if (wr_en && !push_ok) begin
                st_d.ovf = 1'b1;
            end
            if (rd_en && !pop_ok) begin
                st_d.unf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[st_q.wp] <= wr_word;
        end
    end

    assign rd_word = st_q.out;
    assign ovf     = st_q.ovf;
    assign unf     = st_q.unf;

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        sync_req |=> (st_q.cnt == '0) && !st_q.ovf && !st_q.unf);    // R1
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= FULL_CNT);                                       // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst || sync_req)
        st_q.ovf |=> st_q.ovf);                                      // R6
    AST_UNF_STICKY: assert property (@(posedge clk) disable iff (rst || sync_req)
        st_q.unf |=> st_q.unf);                                      // R7
    AST_UNF_HOLDS_DATA: assert property (@(posedge clk) disable iff (rst || sync_req)
        (rd_en && st_q.cnt == '0) |=> $stable(st_q.out));            // R7

endmodule

// File: rtl/lane_skew_buffer.sv
module lane_skew_buffer
    import lsb_pkg::*;
#(
    parameter int unsigned FRAME_BYTES   = 2,
    parameter int unsigned FRAMES_PER_MF = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sync_req,
    input  logic                  wr_valid,
    input  logic [LANE_BITS-1:0]  wr_data,
    input  logic [LANE_BYTES-1:0] wr_ctrl,
    input  logic                  lmfc,
    output logic [LANE_BITS-1:0]  rd_data,
    output logic [LANE_BYTES-1:0] rd_ctrl,
    output logic                  rd_active,
    output logic                  ovf,
    output logic                  unf,
    output logic [LAT_W-1:0]      latency
);

    localparam int unsigned MF_BYTES = FRAME_BYTES * FRAMES_PER_MF;
    localparam int unsigned MF_WORDS = (MF_BYTES + LANE_BYTES - 1) / LANE_BYTES;
    localparam int unsigned DEPTH    = 1 << $clog2((MF_WORDS > 1) ? MF_WORDS : 2);

    lane_word_t in_word;
    lane_word_t out_word;
    logic       has_comma;
    logic       wr_en;
    logic       rd_en;
    logic       push_ok;

    assign in_word.data = wr_data;
    assign in_word.ctrl = wr_ctrl;

    lsb_comma_detect u_comma (
        .word_i      (in_word),
        .has_comma_o (has_comma)
    );

    lsb_start_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .sync_req  (sync_req),
        .wr_valid  (wr_valid),
        .has_comma (has_comma),
        .lmfc      (lmfc),
        .push_ok   (push_ok),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .latency   (latency)
    );

    lsb_fifo #(
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .sync_req (sync_req),
        .wr_en    (wr_en),
        .wr_word  (in_word),
        .rd_en    (rd_en),
        .push_ok  (push_ok),
        .rd_word  (out_word),
        .ovf      (ovf),
        .unf      (unf)
    );

    assign rd_data   = out_word.data;
    assign rd_ctrl   = out_word.ctrl;
    assign rd_active = rd_en;

    AST_CLEAR_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
        sync_req |=> !rd_active && (latency == '0) && (rd_data == '0)); // R1

endmodule

// File: tb/sim_lane_skew_buffer.sv
module sim_lane_skew_buffer;

    localparam time CLK_PERIOD = 10ns;
    localparam int  DEPTH      = 16;
    localparam int  ROWS       = 11;

    typedef struct packed {
        logic        sync;
        logic        valid;
        logic        lmfc;
        logic [31:0] data;
        logic [3:0]  ctrl;
        logic        e_act;
        logic [7:0]  e_lat;
        logic [31:0] e_data;
        logic [3:0]  e_ctrl;
        logic        e_unf;
    } vec_t;

    localparam vec_t TABLE [ROWS] = '{
        '{1'b1, 1'b1, 1'b1, 32'hBCBCBCBC, 4'hF, 1'b0, 8'd0, 32'h00000000, 4'h0, 1'b0},
        '{1'b0, 1'b1, 1'b0, 32'h000000BC, 4'h1, 1'b0, 8'd0, 32'h00000000, 4'h0, 1'b0},
        '{1'b0, 1'b1, 1'b0, 32'h1111117C, 4'h1, 1'b0, 8'd1, 32'h00000000, 4'h0, 1'b0},
        '{1'b0, 1'b1, 1'b1, 32'h22222222, 4'h0, 1'b1, 8'd2, 32'h00000000, 4'h0, 1'b0},
        '{1'b0, 1'b1, 1'b0, 32'h333333BC, 4'h1, 1'b1, 8'd2, 32'h1111117C, 4'h1, 1'b0},
        '{1'b0, 1'b1, 1'b0, 32'h44444444, 4'h0, 1'b1, 8'd2, 32'h22222222, 4'h0, 1'b0},
        '{1'b0, 1'b0, 1'b0, 32'h00000000, 4'h0, 1'b1, 8'd2, 32'h333333BC, 4'h1, 1'b0},
        '{1'b0, 1'b0, 1'b0, 32'h00000000, 4'h0, 1'b1, 8'd2, 32'h44444444, 4'h0, 1'b0},
        '{1'b0, 1'b0, 1'b1, 32'h00000000, 4'h0, 1'b1, 8'd2, 32'h44444444, 4'h0, 1'b1},
        '{1'b0, 1'b1, 1'b0, 32'h55555555, 4'h0, 1'b1, 8'd2, 32'h44444444, 4'h0, 1'b1},
        '{1'b0, 1'b0, 1'b0, 32'h00000000, 4'h0, 1'b1, 8'd2, 32'h55555555, 4'h0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sync_req = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_ctrl = '0;
    logic        lmfc = 1'b0;
    logic [31:0] rd_data;
    logic [3:0]  rd_ctrl;
    logic        rd_active;
    logic        ovf;
    logic        unf;
    logic [7:0]  latency;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lane_skew_buffer u0 (
        .clk       (clk),
        .rst       (rst),
        .sync_req  (sync_req),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .wr_ctrl   (wr_ctrl),
        .lmfc      (lmfc),
        .rd_data   (rd_data),
        .rd_ctrl   (rd_ctrl),
        .rd_active (rd_active),
        .ovf       (ovf),
        .unf       (unf),
        .latency   (latency)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cycle(input logic s, input logic v, input logic l,
                         input logic [31:0] d, input logic [3:0] c);
        sync_req = s;
        wr_valid = v;
        lmfc     = l;
        wr_data  = d;
        wr_ctrl  = c;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // reset state, R1
        rst = 1'b1;
        repeat (3) begin
            @(posedge clk);
        end
        #1;
        check("R1 reset rd_active", 32'(rd_active), 32'd0);
        check("R1 reset latency", 32'(latency), 32'd0);
        check("R1 reset ovf/unf", {30'd0, ovf, unf}, 32'd0);
        check("R1 reset rd_data", rd_data, 32'd0);
        rst = 1'b0;

        // table walk: R2 comma skip, R3 lmfc start, R4 order, R5 latency, R7 underflow
        for (int i = 0; i < ROWS; i++) begin
            cycle(TABLE[i].sync, TABLE[i].valid, TABLE[i].lmfc, TABLE[i].data, TABLE[i].ctrl);
            check($sformatf("R3 row%0d rd_active", i), 32'(rd_active), 32'(TABLE[i].e_act));
            check($sformatf("R5 row%0d latency", i), 32'(latency), 32'(TABLE[i].e_lat));
            check($sformatf("R4 row%0d rd_data", i), rd_data, TABLE[i].e_data);
            check($sformatf("R2 row%0d rd_ctrl", i), 32'(rd_ctrl), 32'(TABLE[i].e_ctrl));
            check($sformatf("R7 row%0d unf", i), 32'(unf), 32'(TABLE[i].e_unf));
        end

        // R1: sync request clears everything
        cycle(1'b1, 1'b0, 1'b0, '0, '0);
        check("R1 sync rd_active", 32'(rd_active), 32'd0);
        check("R1 sync unf", 32'(unf), 32'd0);
        check("R1 sync latency", 32'(latency), 32'd0);
        check("R1 sync rd_data", rd_data, 32'd0);

        // R2: data words offered during sync are discarded
        cycle(1'b1, 1'b1, 1'b1, 32'h12345678, 4'h0);
        cycle(1'b1, 1'b1, 1'b0, 32'h9ABCDEF0, 4'h0);
        check("R2 no store in sync", 32'(latency), 32'd0);

        // R3: lmfc while only commas arrive has no effect
        cycle(1'b0, 1'b1, 1'b1, 32'h00BC0000, 4'h4);
        cycle(1'b0, 1'b1, 1'b1, 32'hBC000000, 4'h8);
        check("R3 comma lmfc rd_active", 32'(rd_active), 32'd0);
        check("R2 comma not stored", 32'(latency), 32'd0);

        // R3: lmfc in the same cycle as the first store is ignored
        cycle(1'b0, 1'b1, 1'b1, 32'hA0A0A0A0, 4'h0);
        check("R3 same-cycle lmfc", 32'(rd_active), 32'd0);
        check("R5 first store", 32'(latency), 32'd1);
        cycle(1'b0, 1'b1, 1'b0, 32'hA1A1A1A1, 4'h0);
        cycle(1'b0, 1'b1, 1'b1, 32'hA2A2A2A2, 4'h0);
        check("R3 next lmfc", 32'(rd_active), 32'd1);
        check("R5 latency three", 32'(latency), 32'd3);
        cycle(1'b0, 1'b0, 1'b0, '0, '0);
        check("R4 first word out", rd_data, 32'hA0A0A0A0);

        // R6: overflow, one write past full
        cycle(1'b1, 1'b0, 1'b0, '0, '0);
        for (int k = 0; k < DEPTH; k++) begin
            cycle(1'b0, 1'b1, 1'b0, 32'hC0000000 + 32'(k), 4'h0);
        end
        check("R6 full no ovf", 32'(ovf), 32'd0);
        cycle(1'b0, 1'b1, 1'b0, 32'hDEADBEEF, 4'h0);
        check("R6 ovf set", 32'(ovf), 32'd1);
        check("R5 latency full", 32'(latency), 32'(DEPTH));
        cycle(1'b0, 1'b0, 1'b1, '0, '0);
        check("R6 rd_active after lmfc", 32'(rd_active), 32'd1);
        cycle(1'b0, 1'b0, 1'b0, '0, '0);
        check("R6 oldest word kept", rd_data, 32'hC0000000);
        cycle(1'b0, 1'b0, 1'b0, '0, '0);
        check("R6 second word kept", rd_data, 32'hC0000001);
        check("R6 ovf sticky", 32'(ovf), 32'd1);
        for (int k = 2; k < DEPTH; k++) begin
            cycle(1'b0, 1'b0, 1'b0, '0, '0);
        end
        check("R6 last kept word", rd_data, 32'hC0000000 + 32'(DEPTH - 1));
        check("R7 no unf yet", 32'(unf), 32'd0);
        cycle(1'b0, 1'b0, 1'b0, '0, '0);
        check("R7 unf on empty read", 32'(unf), 32'd1);
        check("R7 data held", rd_data, 32'hC0000000 + 32'(DEPTH - 1));

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule